// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate Long Unit

This block is a lane-parallel signed arithmetic unit. It takes narrow lanes from one half of two source vectors and multiplies them pairwise. Each product is doubled and clamped to the signed range of a lane twice as wide. The clamped product is then added to, or taken away from, the matching lane of an accumulator vector. That sum or difference is clamped once more before it is written out. Every lane works on its own. One sticky flag per unit records that a clamp occurred anywhere, and it stays set until it is cleared on purpose.

The unit has two pipeline stages. A request presented with `in_valid` appears on `result` two clock edges later, with `out_valid` raised for one cycle. The lane width may be 16 or 32 bits, giving result lanes of 32 or 64 bits. The number of lanes is the register width divided by twice the lane width. A one-lane scalar build uses `REG_W = 2*LANE_W`, for example 16-bit operands with a 32-bit accumulator.

Top module: `dmacl_top`

## Requirements
- R1: Narrow lane i of the selected half is bits [i*LANE_W +: LANE_W] of that half and is a signed integer. Result lane i is bits [i*2*LANE_W +: 2*LANE_W] of `result` and of `acc_in`. There are REG_W/(2*LANE_W) lanes.
- R2: The doubled product 2*a*b is clamped to the signed 2*LANE_W range. This clamp can only trigger when both operands are the most negative narrow value. In that case the product becomes the largest positive wide value.
- R3: `op_sub`=0 adds the clamped product to the accumulator lane, and `op_sub`=1 subtracts it.
- R4: The accumulate result is clamped to the signed 2*LANE_W range: above the range it gives the largest positive value, below it gives the most negative value.
- R5: `sat_flag` goes to 1 on the edge where a result is written if, in any lane, either clamp triggered.
- R6: `sat_flag` keeps its value until `flag_clr` is high on a clock edge. If a new clamp and `flag_clr` arrive on the same edge, the flag ends at 1.
- R7: `half_sel`=0 takes the lanes from the low REG_W/2 bits of both sources, and `half_sel`=1 takes them from the high REG_W/2 bits.
- R8: `out_valid` is high exactly two clock edges after `in_valid` was sampled high, and is low otherwise. `result` keeps its last value while no request completes.
- R9: Each lane's result depends only on its own operands and accumulator. A clamp in one lane leaves the other lanes' results unchanged.
- R10: While `rst_n` is low, `out_valid`, `sat_flag` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| half_sel | input | 1 | Source half select: 0 for low, 1 for high |
| op_sub | input | 1 | 1 to subtract the product, 0 to add it |
| src_a | input | REG_W | First source vector |
| src_b | input | REG_W | Second source vector |
| acc_in | input | REG_W | Accumulator vector of wide lanes |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe |
| result | output | REG_W | Widened, saturated result vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench goes after the one operand pair that overflows the doubling. A design that skipped the first clamp would return the most negative wide value where the largest positive value is expected. It drives the accumulator to both edges of the wide range in both add and subtract mode. A design with only one clamp, or with the clamp directions swapped, would wrap around or pick the wrong rail there. It places a clamp in a single lane and checks that its neighbours are untouched, and it raises `flag_clr` on the same edge as a new clamp, where a design that gave the clear priority would drop the flag. It also checks both source halves and the two-cycle latency, and runs a stream of mixed operands against a reference model in the bench.

// File: rtl/dmacl_pkg.sv
package dmacl_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } acc_op_e;

  function automatic int lane_count(input int reg_w, input int lane_w);
    return reg_w / (2 * lane_w);
  endfunction

endpackage

// File: rtl/dmacl_src_pick.sv
module dmacl_src_pick #(
  parameter int REG_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic                                                      half_sel,
  input  logic [REG_W-1:0]                                          src,
  output logic [dmacl_pkg::lane_count(REG_W, LANE_W)-1:0][LANE_W-1:0] lanes
);
  localparam int HALF_W = REG_W / 2;
  localparam int NL     = dmacl_pkg::lane_count(REG_W, LANE_W);

  logic [HALF_W-1:0] half_lo;
  logic [HALF_W-1:0] half_hi;

  assign half_lo = src[HALF_W-1:0];
  assign half_hi = src[REG_W-1:HALF_W];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lanes[i] = half_sel ? half_hi[i*LANE_W +: LANE_W]
                               : half_lo[i*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/dmacl_lane.sv
module dmacl_lane #(
  parameter int LANE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap1,
  input  logic                  cap2,
  input  logic                  sub_s1,
  input  logic [LANE_W-1:0]     opa,
  input  logic [LANE_W-1:0]     opb,
  input  logic [2*LANE_W-1:0]   acc,
  output logic                  lane_clip,
  output logic [2*LANE_W-1:0]   res
);
  localparam int RW = 2 * LANE_W;
  localparam logic signed [RW-1:0]   POS_MAX  = {1'b0, {(RW-1){1'b1}}};
  localparam logic signed [RW-1:0]   NEG_MIN  = {1'b1, {(RW-1){1'b0}}};
  localparam logic signed [RW+1:0]   WIDE_MAX = {3'b000, {(RW-1){1'b1}}};
  localparam logic [LANE_W-1:0]      SRC_MIN  = {1'b1, {(LANE_W-1){1'b0}}};

  // {clip, value}: doubled product clamped to the wide signed range
  function automatic logic [RW:0] dbl_prod(input logic [LANE_W-1:0] x,
                                           input logic [LANE_W-1:0] y);
    logic signed [RW+1:0] xe;
    logic signed [RW+1:0] ye;
    logic signed [RW+1:0] full;
    xe   = {{(RW+2-LANE_W){x[LANE_W-1]}}, x};
    ye   = {{(RW+2-LANE_W){y[LANE_W-1]}}, y};
    full = (xe * ye) <<< 1;
    if (full > WIDE_MAX) return {1'b1, POS_MAX};
    return {1'b0, full[RW-1:0]};
  endfunction

  // {clip, value}: accumulate with clamp to the wide signed range
  function automatic logic [RW:0] acc_sat(input logic [RW-1:0] a,
                                          input logic [RW-1:0] p,
                                          input logic          sub);
    logic [RW:0] ae;
    logic [RW:0] pe;
    logic [RW:0] s;
    ae = {a[RW-1], a};
    pe = {p[RW-1], p};
    s  = sub ? (ae - pe) : (ae + pe);
    if (s[RW] != s[RW-1]) return {1'b1, (s[RW] ? NEG_MIN : POS_MAX)};
    return {1'b0, s[RW-1:0]};
  endfunction

  // stage 1: doubled, clamped product
  logic [RW:0]   prod_now;
  logic          prod_clip;
  logic [RW-1:0] p1;
  logic          pclip1;
  logic [RW-1:0] acc1;

  assign prod_now  = dbl_prod(opa, opb);
  assign prod_clip = prod_now[RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1     <= '0;
      pclip1 <= 1'b0;
      acc1   <= '0;
    end else if (cap1) begin
      p1     <= prod_now[RW-1:0];
      pclip1 <= prod_clip;
      acc1   <= acc;
    end
  end

  // stage 2: accumulate and clamp
  logic [RW:0] acc_now;
  logic        acc_clip;

  assign acc_now   = acc_sat(acc1, p1, sub_s1);
  assign acc_clip  = acc_now[RW];
  assign lane_clip = pclip1 | acc_clip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res <= '0;
    else if (cap2) res <= acc_now[RW-1:0];
  end

  a_r2_min_pair_clamps: assert property (@(posedge clk) disable iff (!rst_n)
    (cap1 && opa == SRC_MIN && opb == SRC_MIN) |=> (pclip1 && p1 == POS_MAX));

  a_r2_only_min_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (cap1 && !(opa == SRC_MIN && opb == SRC_MIN)) |=> !pclip1);

  a_r4_clamp_to_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (cap2 && acc_clip) |=> (res == POS_MAX || res == NEG_MIN));

  a_r8_res_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap2 |=> $stable(res));

endmodule

// File: rtl/dmacl_sticky.sv
module dmacl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r5_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  a_r6_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/dmacl_top.sv
module dmacl_top #(
  parameter int REG_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             half_sel,
  input  logic             op_sub,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] acc_in,
  input  logic             flag_clr,
  output logic             out_valid,
  output logic [REG_W-1:0] result,
  output logic             sat_flag
);
  import dmacl_pkg::*;

  localparam int NL = lane_count(REG_W, LANE_W);
  localparam int RW = 2 * LANE_W;

  logic [NL-1:0][LANE_W-1:0] lanes_a;
  logic [NL-1:0][LANE_W-1:0] lanes_b;

  dmacl_src_pick #(.REG_W(REG_W), .LANE_W(LANE_W)) u_pick_a (
    .half_sel (half_sel),
    .src      (src_a),
    .lanes    (lanes_a)
  );

  dmacl_src_pick #(.REG_W(REG_W), .LANE_W(LANE_W)) u_pick_b (
    .half_sel (half_sel),
    .src      (src_b),
    .lanes    (lanes_b)
  );

  // valid and operation travel beside the data
  logic    v1;
  acc_op_e op1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      op1       <= OP_ADD;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) op1 <= op_sub ? OP_SUB : OP_ADD;
    end
  end

  logic [NL-1:0] lane_clip;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [RW-1:0] lane_res;
    dmacl_lane #(.LANE_W(LANE_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap1      (in_valid),
      .cap2      (v1),
      .sub_s1    (op1 == OP_SUB),
      .opa       (lanes_a[i]),
      .opb       (lanes_b[i]),
      .acc       (acc_in[i*RW +: RW]),
      .lane_clip (lane_clip[i]),
      .res       (lane_res)
    );
    assign result[i*RW +: RW] = lane_res;
  end

  logic sticky_set;
  assign sticky_set = v1 && (|lane_clip);

  dmacl_sticky u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sticky_set),
    .clr_i  (flag_clr),
    .flag_o (sat_flag)
  );

  a_r8_stage1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1);

  a_r8_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid);

  a_r8_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> !out_valid);

endmodule

// File: tb/dmacl_top_tb.sv
`timescale 1ns/1ps
module dmacl_top_tb;
  localparam int REG_W  = 128;
  localparam int LANE_W = 16;
  localparam int RW     = 2 * LANE_W;
  localparam int NL     = REG_W / RW;
  localparam int HALF_W = REG_W / 2;
  localparam longint WMAX = (64'sd1 <<< (RW - 1)) - 1;
  localparam longint WMIN = -(64'sd1 <<< (RW - 1));

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             half_sel = 1'b0;
  logic             op_sub = 1'b0;
  logic [REG_W-1:0] src_a = '0;
  logic [REG_W-1:0] src_b = '0;
  logic [REG_W-1:0] acc_in = '0;
  logic             flag_clr = 1'b0;
  logic             out_valid;
  logic [REG_W-1:0] result;
  logic             sat_flag;

  int checks = 0;
  int failures = 0;
  bit exp_sticky = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dmacl_top #(.REG_W(REG_W), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_sel(half_sel),
    .op_sub(op_sub), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
    .sat_flag(sat_flag)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: restated from the requirements with plain integer math
  task automatic model(input logic [REG_W-1:0] a, b, acc, input bit half,
                       input bit sub, output logic [REG_W-1:0] r, output bit clip);
    clip = 1'b0;
    r = '0;
    for (int i = 0; i < NL; i++) begin
      int base = (half ? HALF_W : 0) + i * LANE_W;
      longint xa = longint'($signed(a[base +: LANE_W]));
      longint xb = longint'($signed(b[base +: LANE_W]));
      longint ac = longint'($signed(acc[i*RW +: RW]));
      longint p  = 2 * xa * xb;
      longint s;
      if (p > WMAX) begin p = WMAX; clip = 1'b1; end
      s = sub ? ac - p : ac + p;
      if (s > WMAX) begin s = WMAX; clip = 1'b1; end
      if (s < WMIN) begin s = WMIN; clip = 1'b1; end
      r[i*RW +: RW] = s[RW-1:0];
    end
  endtask

  task automatic run_op(input logic [REG_W-1:0] a, b, acc, input bit half,
                        input bit sub, input bit clr_same, input string req);
    logic [REG_W-1:0] er;
    bit clip;
    model(a, b, acc, half, sub, er, clip);
    @(negedge clk);
    src_a = a; src_b = b; acc_in = acc; half_sel = half; op_sub = sub;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = clr_same;
    src_a = ~a; src_b = ~b; acc_in = ~acc;
    chk(out_valid == 1'b0, {req, " R8 one cycle early"}, REG_W'(out_valid), '0);
    @(negedge clk);
    flag_clr = 1'b0;
    if (clip) exp_sticky = 1'b1;
    else if (clr_same) exp_sticky = 1'b0;
    chk(out_valid == 1'b1, {req, " R8 valid"}, REG_W'(out_valid), REG_W'(1));
    chk(result == er, {req, " result"}, result, er);
    chk(sat_flag == exp_sticky, {req, " R5 flag"}, REG_W'(sat_flag), REG_W'(exp_sticky));
  endtask

  function automatic logic [REG_W-1:0] pack_n(input logic [LANE_W-1:0] v0, v1, v2, v3,
                                               input bit hi);
    logic [REG_W-1:0] r = '0;
    r[(hi ? HALF_W : 0) +: HALF_W] = {v3, v2, v1, v0};
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_w(input logic [RW-1:0] v0, v1, v2, v3);
    return {v3, v2, v1, v0};
  endfunction

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10 out_valid", REG_W'(out_valid), '0);
    chk(sat_flag == 1'b0, "R10 sat_flag", REG_W'(sat_flag), '0);
    chk(result == '0, "R10 result", result, '0);
  endtask

  task automatic t_basic;
    run_op(pack_n(16'd3, 16'hFFFE, 16'd100, 16'h7FFF, 0),
           pack_n(16'd5, 16'd7, 16'hFF9C, 16'h7FFF, 0),
           pack_w(32'd10, 32'd0, 32'hFFFF_FFFF, 32'd0), 0, 0, 0, "R1 R3 add low half");
    run_op(pack_n(16'd3, 16'hFFFE, 16'd100, 16'h1234, 0),
           pack_n(16'd5, 16'd7, 16'hFF9C, 16'h0042, 0),
           pack_w(32'd10, 32'd0, 32'hFFFF_FFFF, 32'd77), 0, 1, 0, "R3 subtract");
  endtask

  task automatic t_upper;
    logic [REG_W-1:0] a = pack_n(16'd9, 16'd2, 16'hFFFF, 16'd11, 1);
    logic [REG_W-1:0] b = pack_n(16'd4, 16'd6, 16'd8, 16'd13, 1);
    a[HALF_W-1:0] = {HALF_W{1'b1}};
    b[HALF_W-1:0] = 64'h0123_4567_89AB_CDEF;
    run_op(a, b, pack_w(32'd1, 32'd2, 32'd3, 32'd4), 1, 0, 0, "R7 upper half");
    run_op(a, b, pack_w(32'd1, 32'd2, 32'd3, 32'd4), 0, 0, 0, "R7 lower half");
  endtask

  task automatic t_min_pair;
    run_op(pack_n(16'd2, 16'h8000, 16'd4, 16'h8000, 0),
           pack_n(16'd3, 16'h8000, 16'd5, 16'h7FFF, 0),
           pack_w(32'd1, 32'd0, 32'd2, 32'd0), 0, 0, 0, "R2 R9 min pair clamp");
  endtask

  task automatic t_clear_hold;
    repeat (3) @(negedge clk);
    chk(sat_flag == 1'b1, "R6 flag held", REG_W'(sat_flag), REG_W'(1));
    chk(out_valid == 1'b0, "R8 idle no valid", REG_W'(out_valid), '0);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; exp_sticky = 1'b0;
    chk(sat_flag == 1'b0, "R6 cleared", REG_W'(sat_flag), '0);
  endtask

  task automatic t_acc_rails;
    run_op(pack_n(16'd100, 16'd1, 16'd0, 16'd0, 0),
           pack_n(16'd100, 16'd1, 16'd0, 16'd0, 0),
           pack_w(32'h7FFF_FF00, 32'd5, 32'd6, 32'd7), 0, 0, 0, "R4 R9 add upper rail");
    t_clear_hold();
    run_op(pack_n(16'd100, 16'd1, 16'd0, 16'h8000, 0),
           pack_n(16'd100, 16'd1, 16'd0, 16'd1, 0),
           pack_w(32'h8000_0100, 32'd5, 32'd6, 32'h7FFF_FFF0), 0, 1, 0, "R4 subtract both rails");
    run_op(pack_n(16'd1, 16'd0, 16'd0, 16'h8000, 0),
           pack_n(16'd1, 16'd0, 16'd0, 16'h8000, 0),
           pack_w(32'd0, 32'd0, 32'd0, 32'h0000_0001), 0, 1, 0, "R2 R4 clamped product subtract");
  endtask

  task automatic t_set_beats_clear;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; exp_sticky = 1'b0;
    run_op(pack_n(16'h8000, 16'd0, 16'd0, 16'd0, 0),
           pack_n(16'h8000, 16'd0, 16'd0, 16'd0, 0),
           '0, 0, 0, 1, "R6 set wins over clear");
    run_op(pack_n(16'd1, 16'd1, 16'd1, 16'd1, 0),
           pack_n(16'd1, 16'd1, 16'd1, 16'd1, 0),
           '0, 0, 0, 1, "R6 clear without clip");
  endtask

  task automatic t_stream;
    for (int k = 0; k < 60; k++) begin
      logic [REG_W-1:0] a, b, acc;
      for (int j = 0; j < REG_W / 32; j++) begin
        a[j*32 +: 32]   = $urandom;
        b[j*32 +: 32]   = $urandom;
        acc[j*32 +: 32] = $urandom;
      end
      for (int i = 0; i < REG_W / LANE_W; i++) begin
        if ($urandom % 5 == 0) begin
          a[i*LANE_W +: LANE_W] = 16'h8000;
          b[i*LANE_W +: LANE_W] = 16'h8000;
        end
      end
      run_op(a, b, acc, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), "R1 R9 stream");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_upper();
    t_min_pair();
    t_clear_hold();
    t_acc_rails();
    t_set_beats_clear();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule